// File: doc/BRIEF.md
# Serial HDLC Frame Receiver

This block sits behind a serial line and turns a raw HDLC bit stream into a byte stream for the user logic. The line is sampled one bit per rising edge of the block's own clock. The receiver searches continuously for the 01111110 flag. It removes the zero that a transmitter inserts after every run of five ones. It assembles the remaining bits into octets, least-significant bit first, counting from the flag that opened the frame.

Every octet of a frame is handed out with a one-cycle ready strobe, including both check-sequence octets. The first octet carries a start marker and the last check-sequence octet carries an end marker. Delivery is gated by a space-available input from the user. One cycle after a frame closes, a status byte appears on the same data bus, marked by its own strobe. The status byte reports a bad check sequence, an abort, a frame length that is not a whole number of octets, and octets lost for lack of space.

The block tells three things apart. A run of seven ones inside a frame ends that frame as aborted. A run of fifteen ones marks the line as idle, and this is reported on a separate output. Flags that follow one another directly are only fill and produce no output.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is high and on the first cycle after it, rx_ready, rx_sof, rx_eof, rx_status and line_idle are all low.
- R2: After a flag (line bits 0,1,1,1,1,1,1,0), the receiver groups the following de-stuffed bits into octets, with the first bit received placed in bit 0. Each octet is delivered with a one-cycle rx_ready, in order.
- R3: A 0 received after exactly five consecutive 1s is dropped and is not part of any octet.
- R4: The first octet delivered in a frame has rx_sof high. The last check-sequence octet has rx_eof high, and both check-sequence octets are delivered as data. rx_sof and rx_eof are only ever high together with rx_ready.
- R5: For every frame that has delivered at least one octet, the cycle after its end carries rx_status high, with a status byte on rx_data. Bit 0 means check sequence bad, bit 1 means abort, bit 2 means the length is not a whole number of octets, bit 3 means overrun, and bits 7:4 are zero. After rx_eof, rx_status follows on the next cycle.
- R6: The check sequence is CRC-16 with polynomial x^16+x^15+x^2+1, processed least-significant bit first from an all-ones start value. A frame is good when the remainder over payload plus check sequence is zero. A good frame reports status 0x00 and a corrupted one reports bit 0 set.
- R7: Seven consecutive 1s inside a frame abort it. The octet still held back is discarded, no rx_eof is given, and the status byte is 0x02.
- R8: line_idle goes high once fifteen consecutive 1s have been received, stays low after only fourteen, and drops on the cycle after a 0.
- R9: An octet due for delivery while space_ok is low is dropped without rx_ready, and the frame's status byte has bit 3 set.
- R10: Back-to-back flags, and a frame that closes with fewer than two whole octets and no octet yet released, produce no rx_ready and no rx_status.
- R11: A frame whose bit count is not a multiple of eight delivers all its whole octets with no rx_eof. Its status has bit 2 set, and bit 0 reflects the CRC remainder over all its bits.
- R12: rx_ready and rx_status are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial line data |
| space_ok | input | 1 | User can accept an octet this cycle |
| rx_data | output | 8 | Delivered octet, or status byte when rx_status is high |
| rx_ready | output | 1 | rx_data holds a frame octet |
| rx_sof | output | 1 | Octet is the first of its frame |
| rx_eof | output | 1 | Octet is the last check-sequence octet |
| rx_status | output | 1 | rx_data holds the frame status byte |
| line_idle | output | 1 | Fifteen or more consecutive ones seen |

## Verification
The assertions watch, on every cycle, how the output strobes relate to one another. They check that the ready and status strobes are exclusive, that the markers appear only with ready, that status follows the end marker, that no octet is delivered without space, and that a zero clears the idle indication. They do not check the octet values, the bit order, stuffing removal, the CRC verdict or when a frame is dropped. Those are shown only by the bench's frame sweeps: payload lengths and bit patterns that force stuffing across octet boundaries, plus deliberate corruption, abort, truncation, short-frame and back-to-back-flag scenarios compared against expected octets and status bytes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  // Status byte bit positions, decoded by the user logic.
  localparam int ST_FCS_BAD  = 0;
  localparam int ST_ABORT    = 1;
  localparam int ST_ODD_BITS = 2;
  localparam int ST_OVERRUN  = 3;
  localparam int OCTET_W     = 8;
endpackage

// File: rtl/hdlc_rx_line.sv
// Line-level decoding: flag match, run-of-ones tracking, zero removal tags,
// and an eight-bit delay window so that flag bits never reach the octet packer.
module hdlc_rx_line #(
  parameter int STUFF_RUN = 5,
  parameter int ABORT_RUN = 7,
  parameter int IDLE_RUN  = 15,
  parameter logic [7:0] FLAG = 8'h7E
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  output logic bit_out,
  output logic bit_vld,
  output logic flag_hit,
  output logic abort_hit,
  output logic line_idle
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] K_STUFF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] K_PRE_ABORT = RUN_W'(ABORT_RUN - 1);
  localparam logic [RUN_W-1:0] K_IDLE = RUN_W'(IDLE_RUN);

  logic [7:0]       win, tag;
  logic [RUN_W-1:0] run, run_n;
  logic             stuffed;

  always_comb begin
    if (!rx_bit)           run_n = '0;
    else if (run >= K_IDLE) run_n = run;
    else                   run_n = run + 1'b1;
    stuffed   = !rx_bit && (run == K_STUFF);
    flag_hit  = ({win[6:0], rx_bit} == FLAG);
    abort_hit = rx_bit && (run == K_PRE_ABORT);
    bit_out   = win[7];
    bit_vld   = tag[7];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win       <= '0;
      tag       <= '0;
      run       <= '0;
      line_idle <= 1'b0;
    end else begin
      win       <= {win[6:0], rx_bit};
      tag       <= flag_hit ? 8'h00 : {tag[6:0], !stuffed};
      run       <= run_n;
      line_idle <= (run_n >= K_IDLE);
    end
  end

  // R8: a zero on the line always removes the idle indication next cycle
  a_r8_zero_clears_idle: assert property (@(posedge clk) disable iff (rst)
    !rx_bit |=> !line_idle);
  // R7: an abort can only be flagged when the previous line bit was a one
  a_r7_abort_follows_one: assert property (@(posedge clk) disable iff (rst)
    abort_hit |-> $past(rx_bit));
endmodule

// File: rtl/hdlc_rx_crc.sv
// Bit-serial CRC, least-significant bit first, with a look-ahead output.
module hdlc_rx_crc #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY_R = 16'hA001,
  parameter logic [W-1:0] INIT   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_d
);
  always_comb begin
    if (en) crc_d = {1'b0, crc_q[W-1:1]} ^ ((crc_q[0] ^ din) ? POLY_R : '0);
    else    crc_d = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= INIT;
    else            crc_q <= crc_d;
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int FCS_W = 16,
  parameter logic [FCS_W-1:0] CRC_POLY_R = 16'hA001,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_RUN = 7,
  parameter int IDLE_RUN  = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_bit,
  input  logic       space_ok,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       rx_sof,
  output logic       rx_eof,
  output logic       rx_status,
  output logic       line_idle
);
  import hdlc_rx_pkg::*;

  localparam int MIN_BYTES = FCS_W / OCTET_W;
  localparam int NB_W = $clog2(MIN_BYTES + 1);
  localparam logic [NB_W-1:0] K_MIN = NB_W'(MIN_BYTES);

  logic bit_out, bit_vld, flag_hit, abort_hit;
  logic [FCS_W-1:0] crc_q, crc_d;

  logic             in_frame, held_v, released, overrun, stat_pend;
  logic [2:0]       bitcnt, bitcnt_n;
  logic [7:0]       acc, acc_n, held, held_n, out_byte, stat_q, stat_n;
  logic [NB_W-1:0]  nbytes, nbytes_n;
  logic             commit, byte_done, push, held_v_n, frame_end, frame_abort;
  logic             last_out, deliver, released_n, ovr_n, report;

  hdlc_rx_line #(
    .STUFF_RUN(STUFF_RUN), .ABORT_RUN(ABORT_RUN), .IDLE_RUN(IDLE_RUN)
  ) i_line (
    .clk(clk), .rst(rst), .rx_bit(rx_bit),
    .bit_out(bit_out), .bit_vld(bit_vld), .flag_hit(flag_hit),
    .abort_hit(abort_hit), .line_idle(line_idle)
  );

  hdlc_rx_crc #(.W(FCS_W), .POLY_R(CRC_POLY_R)) i_crc (
    .clk(clk), .rst(rst), .clr(flag_hit || frame_abort),
    .en(commit), .din(bit_out), .crc_q(crc_q), .crc_d(crc_d)
  );

  always_comb begin
    commit      = in_frame && bit_vld;
    acc_n       = {bit_out, acc[7:1]};
    byte_done   = commit && (bitcnt == 3'd7);
    push        = commit && (bitcnt == 3'd0) && held_v;
    bitcnt_n    = commit ? bitcnt + 3'd1 : bitcnt;
    held_n      = byte_done ? acc_n : held;
    held_v_n    = byte_done ? 1'b1 : (push ? 1'b0 : held_v);
    nbytes_n    = (byte_done && nbytes != K_MIN) ? nbytes + 1'b1 : nbytes;
    frame_end   = in_frame && flag_hit;
    frame_abort = in_frame && abort_hit && !flag_hit;
    last_out    = frame_end && (bitcnt_n == 3'd0) && held_v_n && (nbytes_n == K_MIN);
    deliver     = push || last_out;
    out_byte    = push ? held : held_n;
    released_n  = released || deliver;
    ovr_n       = overrun || (deliver && !space_ok);
    report      = (frame_end || frame_abort) && released_n;
    stat_n      = '0;
    stat_n[ST_OVERRUN] = ovr_n;
    if (frame_abort) begin
      stat_n[ST_ABORT] = 1'b1;
    end else begin
      stat_n[ST_FCS_BAD]  = (crc_d != '0);
      stat_n[ST_ODD_BITS] = (bitcnt_n != 3'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_ready  <= 1'b0;
      rx_sof    <= 1'b0;
      rx_eof    <= 1'b0;
      rx_status <= 1'b0;
      stat_pend <= 1'b0;
      stat_q    <= '0;
      in_frame  <= 1'b0;
      bitcnt    <= '0;
      acc       <= '0;
      held      <= '0;
      held_v    <= 1'b0;
      nbytes    <= '0;
      released  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rx_ready  <= 1'b0;
      rx_sof    <= 1'b0;
      rx_eof    <= 1'b0;
      rx_status <= 1'b0;
      if (deliver && space_ok) begin
        rx_ready <= 1'b1;
        rx_data  <= out_byte;
        rx_sof   <= !released;
        rx_eof   <= last_out;
      end else if (stat_pend) begin
        rx_status <= 1'b1;
        rx_data   <= stat_q;
      end
      stat_pend <= report;
      if (report) stat_q <= stat_n;

      if (flag_hit || frame_abort) begin
        in_frame <= flag_hit;
        bitcnt   <= '0;
        held_v   <= 1'b0;
        nbytes   <= '0;
        released <= 1'b0;
        overrun  <= 1'b0;
      end else if (in_frame) begin
        if (commit) acc <= acc_n;
        bitcnt   <= bitcnt_n;
        held     <= held_n;
        held_v   <= held_v_n;
        nbytes   <= nbytes_n;
        released <= released_n;
        overrun  <= ovr_n;
      end
    end
  end

  // R12: data and status never share a cycle on the bus
  a_r12_ready_status_excl: assert property (@(posedge clk) disable iff (rst)
    !(rx_ready && rx_status));
  // R4: markers only travel with a delivered octet
  a_r4_sof_with_ready: assert property (@(posedge clk) disable iff (rst)
    rx_sof |-> rx_ready);
  a_r4_eof_with_ready: assert property (@(posedge clk) disable iff (rst)
    rx_eof |-> rx_ready);
  // R5: the status byte directly follows the end marker
  a_r5_status_after_eof: assert property (@(posedge clk) disable iff (rst)
    rx_eof |=> rx_status);
  // R9: no octet is presented unless the user had space
  a_r9_ready_needs_space: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> $past(space_ok));
  // R7: an abort leaves frame mode
  a_r7_abort_leaves_frame: assert property (@(posedge clk) disable iff (rst)
    frame_abort |=> !in_frame);
endmodule

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0;
  logic       space_ok = 1'b1;
  logic [7:0] rx_data;
  logic       rx_ready, rx_sof, rx_eof, rx_status, line_idle;

  always #4 clk = ~clk;

  hdlc_rx_deframer i_hdlc_rx_deframer (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .space_ok(space_ok),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_status(rx_status), .line_idle(line_idle)
  );

  int n_checks = 0;
  int n_err = 0;
  int ones_tx = 0;
  logic wd_fired = 1'b0;

  // monitor: only this process writes the capture state
  logic [7:0] cap_d [0:1023];
  logic       cap_s [0:1023];
  logic       cap_e [0:1023];
  int cap_total = 0;
  int stat_total = 0;
  int overlap = 0;
  logic [7:0] last_stat = 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_ready && rx_status) overlap++;
      if (rx_ready && cap_total < 1024) begin
        cap_d[cap_total] = rx_data;
        cap_s[cap_total] = rx_sof;
        cap_e[cap_total] = rx_eof;
        cap_total++;
      end
      if (rx_status) begin
        stat_total++;
        last_stat = rx_data;
      end
    end
  end

  logic [7:0] fr [0:15];

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_raw(input logic b);
    rx_bit = b;
    @(negedge clk);
  endtask

  task automatic send_dbit(input logic b);
    send_raw(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin
        send_raw(1'b0);
        ones_tx = 0;
      end
    end else begin
      ones_tx = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    ones_tx = 0;
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {1'b0, c[15:1]} ^ ((c[0] ^ b) ? 16'hA001 : 16'h0000);
  endfunction

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) c = crc_step(c, fr[k][i]);
    return c;
  endfunction

  // compare captured octets and the single status byte against expectations
  task automatic check_frame(input string tag, input int cbase, input int sbase,
                             input int nexp, input logic [7:0] exp_stat, input logic exp_eof);
    chk({tag, " octet count"}, cap_total - cbase, nexp);
    for (int k = 0; k < nexp && (cbase + k) < cap_total; k++) begin
      chk({tag, " R2 octet value"}, cap_d[cbase+k], fr[k]);
      chk({tag, " R4 sof marker"}, cap_s[cbase+k], (k == 0) ? 1 : 0);
      chk({tag, " R4 eof marker"}, cap_e[cbase+k], (exp_eof && k == nexp - 1) ? 1 : 0);
    end
    chk({tag, " R5 status count"}, stat_total - sbase, 1);
    chk({tag, " R5 status byte"}, last_stat, exp_stat);
  endtask

  task automatic good_frame(input int n, input int pat, input logic corrupt);
    int cb, sb;
    logic [15:0] c;
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: fr[k] = 8'hFF;
        1: fr[k] = 8'h7E;
        2: fr[k] = 8'(k * 37 + n * 11 + 3);
        default: fr[k] = 8'hF8 ^ 8'(k);
      endcase
    end
    c = crc_of(n);
    fr[n] = c[7:0];
    fr[n+1] = c[15:8];
    if (corrupt) fr[0] = fr[0] ^ 8'h01;
    cb = cap_total;
    sb = stat_total;
    send_flag();
    for (int k = 0; k < n + 2; k++) send_byte(fr[k]);
    send_flag();
    send_flag();
    if (corrupt) check_frame("R6 corrupted", cb, sb, n + 2, 8'h01, 1'b1);
    else if (pat < 2) check_frame("R3 stuffed", cb, sb, n + 2, 8'h00, 1'b1);
    else check_frame("R6 good", cb, sb, n + 2, 8'h00, 1'b1);
  endtask

  task automatic run_all();
    int cb, sb;
    logic [15:0] c;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", rx_ready, 0);
    chk("R1 status in reset", rx_status, 0);
    chk("R1 idle in reset", line_idle, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sof after reset", rx_sof, 0);
    chk("R1 eof after reset", rx_eof, 0);
    send_flag();
    send_flag();

    // R2 R3 R4 R6: sweep of lengths and patterns
    for (int n = 0; n < 6; n++)
      for (int p = 0; p < 4; p++) good_frame(n, p, 1'b0);
    good_frame(3, 2, 1'b1);

    // R10: flag fill only, then a one-octet frame
    cb = cap_total; sb = stat_total;
    repeat (4) send_flag();
    send_byte(8'h5A);
    send_flag();
    send_flag();
    chk("R10 no octets", cap_total - cb, 0);
    chk("R10 no status", stat_total - sb, 0);

    // R9: no space for the whole frame
    space_ok = 1'b0;
    cb = cap_total; sb = stat_total;
    for (int k = 0; k < 4; k++) fr[k] = 8'(k + 1);
    c = crc_of(4);
    fr[4] = c[7:0]; fr[5] = c[15:8];
    send_flag();
    for (int k = 0; k < 6; k++) send_byte(fr[k]);
    send_flag();
    send_flag();
    space_ok = 1'b1;
    chk("R9 no ready", cap_total - cb, 0);
    chk("R9 status count", stat_total - sb, 1);
    chk("R9 overrun status", last_stat, 8'h08);

    // R7: abort after four octets
    fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33; fr[3] = 8'h04;
    cb = cap_total; sb = stat_total;
    send_flag();
    for (int k = 0; k < 4; k++) send_byte(fr[k]);
    repeat (8) send_raw(1'b1);
    send_flag();
    send_flag();
    check_frame("R7 abort", cb, sb, 3, 8'h02, 1'b0);

    // R11: three octets plus three extra bits
    cb = cap_total; sb = stat_total;
    send_flag();
    for (int k = 0; k < 3; k++) send_byte(fr[k]);
    repeat (3) send_dbit(1'b0);
    send_flag();
    send_flag();
    c = crc_of(3);
    repeat (3) c = crc_step(c, 1'b0);
    check_frame("R11 odd length", cb, sb, 3, (c != 16'h0) ? 8'h05 : 8'h04, 1'b0);

    // R8: idle detection
    sb = stat_total;
    repeat (14) send_raw(1'b1);
    chk("R8 fourteen ones", line_idle, 0);
    send_raw(1'b1);
    chk("R8 fifteen ones", line_idle, 1);
    send_raw(1'b1);
    chk("R8 still idle", line_idle, 1);
    send_raw(1'b0);
    chk("R8 zero clears", line_idle, 0);
    send_flag();
    send_flag();
    chk("R10 silent abort on idle", stat_total - sb, 0);

    chk("R12 ready/status overlap", overlap, 0);
  endtask

  initial begin
    run_all();
    if (!wd_fired) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fired = 1'b1;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err + 1, n_checks + 1);
    $finish;
  end
endmodule